// File: doc/BRIEF.md
# Overflow Reporting Control Register

This block is a 64-bit control register that decides how a performance-monitor overflow is reported. It has three fields. A two-bit capture field enables snapshot capture events and says whether they are allowed. A single bit gates profiling exceptions taken at the current privilege level. A two-bit mode field selects whether an overflow drives a level interrupt or requests a synchronous profiling exception.

Two strap inputs say which optional features are present. A field whose feature is absent reads as zero and ignores writes. The outputs are combinational: they are derived from the stored fields, the overflow-pending input and the current privilege level. The block does not decide whether an access is permitted, does not hold the overflow counters and does not deliver exceptions.

Top module: `pmu_ovf_ctrl`

## Requirements
- R1: After reset, every implemented field is zero, so rd_data reads 0.
- R2: rd_data bits 63..5 always read zero, whatever value was written to those bits.
- R3: The capture field sits at rd_data[4:3] and is loaded from wr_data[4:3] on a clock edge with wr_en high, but only while has_snap is 1. A written 01 is stored as 00. While has_snap is 0, the field reads 00 and writes leave it unchanged.
- R4: cap_en_o is 1 when the capture field is 10 or 11. cap_allow_o is 1 only when the field is 11.
- R5: The local enable bit sits at rd_data[2] and the mode field at rd_data[1:0]. Both are loaded from the matching bits of wr_data on a write, but only while has_exc is 1. A written mode of 01 is stored as 00. While has_exc is 0, bits 2..0 read 0 and writes leave them unchanged.
- R6: While the mode reads 00, irq_o equals ovf_pend in the same cycle. In modes 10 and 11, irq_o is 0.
- R7: prof_exc_o is 1 exactly when all of the following hold: the mode is 11, the local enable bit is 1, ovf_pend is 1, and cur_lvl (0 to 3) is 0 or 1.
- R8: A write takes effect on the clock edge. In the cycle of the write, irq_o and prof_exc_o still follow the previously stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current register contents |
| has_snap | input | 1 | Strap: capture feature present |
| has_exc | input | 1 | Strap: exception-based overflow feature present |
| ovf_pend | input | 1 | Overflow pending |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| irq_o | output | 1 | Overflow interrupt level |
| prof_exc_o | output | 1 | Profiling-exception request |
| cap_en_o | output | 1 | Capture events enabled |
| cap_allow_o | output | 1 | Capture events allowed |

## Verification
A write that changes the mode field can arrive in the same cycle as a pending overflow. The bench provokes this in directed steps: for example, it writes mode 11 while the stored mode is 00 and ovf_pend is high. It also does this at random throughout the run. In the write cycle, the bench expects irq_o and prof_exc_o to reflect the old mode. In the next cycle, it expects them to reflect the new mode.

// File: rtl/pmu_ovf_ctrl.sv
module pmu_ovf_ctrl #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              has_snap,
  input  logic              has_exc,
  input  logic              ovf_pend,
  input  logic [1:0]        cur_lvl,
  output logic              irq_o,
  output logic              prof_exc_o,
  output logic              cap_en_o,
  output logic              cap_allow_o
);
  localparam int FIELD_W = 5;
  localparam logic [1:0] MODE_IRQ = 2'b00;
  localparam logic [1:0] MODE_EXC = 2'b11;
  localparam logic [1:0] CODE_RSV = 2'b01;

  logic [1:0] snap_q, mode_q;
  logic       lcl_q;
  logic [1:0] snap_v, mode_v;
  logic       lcl_v;
  logic       unused_hi;

  function automatic logic [1:0] legalize(input logic [1:0] v);
    return (v == CODE_RSV) ? 2'b00 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      lcl_q  <= 1'b0;
      mode_q <= '0;
    end else if (wr_en) begin
      if (has_snap) snap_q <= legalize(wr_data[4:3]);
      if (has_exc) begin
        lcl_q  <= wr_data[2];
        mode_q <= legalize(wr_data[1:0]);
      end
    end
  end

  assign snap_v = has_snap ? snap_q : 2'b00;
  assign lcl_v  = has_exc & lcl_q;
  assign mode_v = has_exc ? mode_q : 2'b00;

  assign rd_data     = {{(DATA_W-FIELD_W){1'b0}}, snap_v, lcl_v, mode_v};
  assign irq_o       = ovf_pend & (mode_v == MODE_IRQ);
  assign prof_exc_o  = ovf_pend & (mode_v == MODE_EXC) & lcl_v & (cur_lvl <= 2'd1);
  assign cap_en_o    = snap_v[1];
  assign cap_allow_o = &snap_v;
  assign unused_hi   = ^wr_data[DATA_W-1:FIELD_W];
endmodule

// File: rtl/pmu_ovf_ctrl_chk.sv
module pmu_ovf_ctrl_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              has_snap,
  input logic              has_exc,
  input logic              ovf_pend,
  input logic [1:0]        cur_lvl,
  input logic              irq_o,
  input logic              prof_exc_o,
  input logic              cap_en_o,
  input logic              cap_allow_o
);
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[DATA_W-1:5] == '0); // R2
  AST_SNAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rd_data[4:3] != 2'b01); // R3
  AST_SNAP_ABSENT: assert property (@(posedge clk) disable iff (!rst_n) !has_snap |-> rd_data[4:3] == 2'b00); // R3
  AST_CAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n) cap_allow_o |-> cap_en_o); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rd_data[1:0] != 2'b01); // R5
  AST_EXC_ABSENT: assert property (@(posedge clk) disable iff (!rst_n) !has_exc |-> rd_data[2:0] == 3'b000); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) rd_data[1] |-> !irq_o); // R6
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[1:0] == 2'b00) |-> irq_o == ovf_pend); // R6
  AST_EXC_COND: assert property (@(posedge clk) disable iff (!rst_n)
    prof_exc_o |-> (rd_data[2:0] == 3'b111 && ovf_pend && cur_lvl <= 2'd1)); // R7
  AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && has_snap && has_exc) |=> (!$stable({has_snap, has_exc}) || $stable(rd_data[4:0]))); // R8
endmodule

bind pmu_ovf_ctrl pmu_ovf_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .has_snap(has_snap), .has_exc(has_exc), .ovf_pend(ovf_pend), .cur_lvl(cur_lvl),
  .irq_o(irq_o), .prof_exc_o(prof_exc_o), .cap_en_o(cap_en_o), .cap_allow_o(cap_allow_o)
);

// File: tb/test_pmu_ovf_ctrl.sv
`timescale 1ns/1ps
module test_pmu_ovf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        has_snap = 1'b1, has_exc = 1'b1, ovf_pend = 1'b0;
  logic [1:0]  cur_lvl = 2'd0;
  logic        irq_o, prof_exc_o, cap_en_o, cap_allow_o;
  int checks = 0, errors = 0;
  logic [1:0] m_snap = 2'b00, m_mode = 2'b00;
  logic       m_lcl = 1'b0;

  always #10 clk = ~clk;

  pmu_ovf_ctrl i_pmu_ovf_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .has_snap(has_snap), .has_exc(has_exc), .ovf_pend(ovf_pend), .cur_lvl(cur_lvl),
    .irq_o(irq_o), .prof_exc_o(prof_exc_o), .cap_en_o(cap_en_o), .cap_allow_o(cap_allow_o)
  );

  function automatic logic [1:0] fix(input logic [1:0] v);
    return (v == 2'b01) ? 2'b00 : v;
  endfunction
  function automatic logic [63:0] exp_rd();
    logic [1:0] s = has_snap ? m_snap : 2'b00;
    logic [2:0] e = has_exc ? {m_lcl, m_mode} : 3'b000;
    return {59'd0, s, e};
  endfunction
  function automatic logic exp_irq();
    return ovf_pend && exp_rd() [1:0] == 2'b00;
  endfunction
  function automatic logic exp_exc();
    return ovf_pend && exp_rd() [2:0] == 3'b111 && cur_lvl <= 2'd1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [63:0] r = exp_rd();
    check({tag, " R2/R3/R5 rd_data"}, rd_data, r);
    check({tag, " R4 cap_en"}, {63'd0, cap_en_o}, {63'd0, r[4]});
    check({tag, " R4 cap_allow"}, {63'd0, cap_allow_o}, {63'd0, r[4] & r[3]});
    check({tag, " R6 irq"}, {63'd0, irq_o}, {63'd0, exp_irq()});
    check({tag, " R7 exc"}, {63'd0, prof_exc_o}, {63'd0, exp_exc()});
  endtask

  task automatic step(input string tag, input logic we, input logic [63:0] d, input logic ov,
                      input logic [1:0] lv, input logic hs, input logic he);
    @(negedge clk);
    wr_en = we; wr_data = d; ovf_pend = ov; cur_lvl = lv; has_snap = hs; has_exc = he;
    #1 check_all(tag);
    @(posedge clk);
    if (we) begin
      if (hs) m_snap = fix(d[4:3]);
      if (he) begin m_lcl = d[2]; m_mode = fix(d[1:0]); end
    end
  endtask

  initial begin
    #3_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4127));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 reset value", rd_data, 64'd0);
    step("R2 all ones", 1'b1, '1, 1'b1, 2'd0, 1'b1, 1'b1);
    step("R2 readback", 1'b0, '0, 1'b1, 2'd0, 1'b1, 1'b1);
    step("R3 R5 reserved", 1'b1, 64'h0000_0000_0000_0009, 1'b1, 2'd1, 1'b1, 1'b1);
    step("R3 R5 reserved rb", 1'b0, '0, 1'b1, 2'd1, 1'b1, 1'b1);
    step("R8 write mode11 with ovf", 1'b1, 64'h7, 1'b1, 2'd0, 1'b1, 1'b1);
    step("R8 next cycle", 1'b0, '0, 1'b1, 2'd0, 1'b1, 1'b1);
    step("R7 level 2", 1'b0, '0, 1'b1, 2'd2, 1'b1, 1'b1);
    step("R7 level 3", 1'b0, '0, 1'b1, 2'd3, 1'b1, 1'b1);
    step("R7 local off", 1'b1, 64'h3, 1'b1, 2'd1, 1'b1, 1'b1);
    step("R6 mode10", 1'b1, 64'h12, 1'b1, 2'd1, 1'b1, 1'b1);
    step("R3 strap off write", 1'b1, 64'h1F, 1'b1, 2'd0, 1'b0, 1'b0);
    step("R5 strap off read", 1'b0, '0, 1'b1, 2'd0, 1'b0, 1'b0);
    step("R3 strap back on", 1'b0, '0, 1'b1, 2'd0, 1'b1, 1'b1);
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [3:0] k = 4'($urandom);
      step("rand", k[0], d, k[1], 2'($urandom), k[3:2] != 2'b00, k[3:2] != 2'b01);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule